// File: doc/BRIEF.md
# Bundle Header Parser with Escape Decoding

This block reads the fixed-size header at the front of one variable-length instruction bundle. The bundle is made of several blocks of operation slots. The header holds two kinds of field. The first is the bundle length in bits, which is the shift distance to the next bundle. The second is a slot count for every block except the final one. The parser works out the count of the final block from the length that is left over. It then reports the bit offset where each block begins and how many slots each block holds, so a downstream slot decoder can cut the bundle apart.

A count field can hold values above the largest legal slot count. Such a value never describes a real layout. It is decoded as a complete zero-argument operation, such as a no-op or a value-less return, and takes no bits beyond the header. If the leftover length cannot hold a whole number of final-block slots, or needs too many of them, the parser flags a length error and reports no layout.

Headers enter on a valid/ready input and results leave on a valid/ready output through one register stage. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While a result waits with `out_ready` low, the result is held unchanged and no new header is taken. A sender must hold `in_hdr` steady while `in_valid` is high and `in_ready` is low.

Top module: `bundle_hdr_parser`

## Requirements
- R1: With the default parameters, `in_hdr[7:0]` is the bundle length in bits. The count field of block b (b = 0, 1, 2) sits at `in_hdr[8+3b +: 3]`. The header is 17 bits wide and block 3 has no count field.
- R2: For every accepted header, `out_len` equals the header length field, whether the result is a layout, an escape or an error.
- R3: Slot widths are 4, 8 and 12 bits for blocks 0 to 2 and 17 bits for block 3. Block 0 starts at bit 17. Block b+1 starts at the start of block b plus its count times its slot width. Starts are packed in `out_start[8b +: 8]`.
- R4: The count of block 3 is the length minus the start of block 3, divided by 17. Counts are packed in `out_cnt[3b +: 3]`, and blocks 0 to 2 echo their header fields.
- R5: If the start of block 3 lies beyond the length, the remainder is not a multiple of 17, or the derived count exceeds 5, then `out_err` is 1, `out_esc` is 0, and `out_cnt` and `out_start` are all zero.
- R6: If any count field holds 6 or 7, then `out_esc` is 1, `out_err` is 0, and counts and starts are zero. `out_esc_code` is 2b + (value − 6) for the lowest such block b. An escape takes precedence over a length error.
- R7: A result appears on the output exactly one cycle after its header is accepted. Results leave in the order their headers were accepted, and none is lost or repeated.
- R8: `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value into the next cycle.
- R9: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Header on `in_hdr` is offered |
| in_ready | output | 1 | Parser can take a header this cycle |
| in_hdr | input | 17 | Bundle-aligned header bits |
| out_valid | output | 1 | A parsed result is held on the outputs |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_len | output | 8 | Bundle length in bits (shift count) |
| out_cnt | output | 12 | Slot count per block, 3 bits each |
| out_start | output | 32 | Start bit offset per block, 8 bits each |
| out_esc | output | 1 | Header encodes a zero-argument operation |
| out_esc_code | output | 3 | Which zero-argument operation |
| out_err | output | 1 | Length does not fit a legal layout |

## Verification
Every parsed field is due in the cycle right after the accepting edge. It stays valid until the edge where `out_ready` is also high. `in_ready` responds to `out_valid` and `out_ready` within the same cycle. The bench drives inputs at the falling edge and samples a quarter period later, so it sees the values that the next rising edge will act on. At each sample it pairs a consumed result with the oldest expected result in a queue that is filled at acceptance. It also confirms that `out_valid` rose one cycle after each acceptance and that a stalled result is identical one cycle later.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

  // Slot width of block blk: morsel count grows with the block index, and the
  // final block carries one extra bit.
  function automatic int unsigned slot_width(int unsigned blk, int unsigned nblk,
                                             int unsigned morsel);
    return (blk + 1) * morsel + ((blk == nblk - 1) ? 1 : 0);
  endfunction

endpackage

// File: rtl/bhp_layout.sv
module bhp_layout #(
  parameter int unsigned NUM_BLK  = 4,
  parameter int unsigned LEN_W    = 8,
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned MAX_CNT  = 5,
  parameter int unsigned MORSEL_W = 4,
  parameter int unsigned HDR_W    = LEN_W + (NUM_BLK - 1) * CNT_W
) (
  input  logic [LEN_W-1:0]               len,
  input  logic [(NUM_BLK-1)*CNT_W-1:0]   cnt_enc,
  output logic [NUM_BLK*CNT_W-1:0]       cnt_all,
  output logic [NUM_BLK*LEN_W-1:0]       start_all,
  output logic                           bad
);
  localparam int unsigned SUM_W   = LEN_W + CNT_W + 6;
  localparam int unsigned SW_LAST = bhp_pkg::slot_width(NUM_BLK - 1, NUM_BLK, MORSEL_W);

  logic [SUM_W-1:0] acc [NUM_BLK];
  logic [NUM_BLK-1:0] hi_bits;
  logic [SUM_W-1:0] len_ext, rem, quo, md;
  logic neg;

  assign acc[0] = SUM_W'(HDR_W);

  for (genvar b = 0; b < NUM_BLK - 1; b++) begin : g_chain
    localparam int unsigned SW = bhp_pkg::slot_width(b, NUM_BLK, MORSEL_W);
    assign acc[b+1] = acc[b] + SUM_W'(cnt_enc[b*CNT_W +: CNT_W]) * SUM_W'(SW);
    assign cnt_all[b*CNT_W +: CNT_W] = cnt_enc[b*CNT_W +: CNT_W];
  end

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_start
    assign start_all[b*LEN_W +: LEN_W] = acc[b][LEN_W-1:0];
    assign hi_bits[b] = |acc[b][SUM_W-1:LEN_W];
  end

  // Final block: whatever length remains, in whole slots.
  assign len_ext = SUM_W'(len);
  assign neg     = acc[NUM_BLK-1] > len_ext;
  assign rem     = len_ext - acc[NUM_BLK-1];
  assign quo     = rem / SUM_W'(SW_LAST);
  assign md      = rem % SUM_W'(SW_LAST);
  assign cnt_all[(NUM_BLK-1)*CNT_W +: CNT_W] = quo[CNT_W-1:0];

  assign bad = neg || (|hi_bits) || (md != '0) || (quo > SUM_W'(MAX_CNT));
endmodule

// File: rtl/bhp_esc_detect.sv
module bhp_esc_detect #(
  parameter int unsigned NUM_BLK = 4,
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned MAX_CNT = 5,
  parameter int unsigned ESC_W   = 3
) (
  input  logic [(NUM_BLK-1)*CNT_W-1:0] cnt_enc,
  output logic                         hit,
  output logic [ESC_W-1:0]             code
);
  localparam int unsigned PER = (1 << CNT_W) - MAX_CNT - 1;

  logic [CNT_W-1:0] fld;

  // Scan from the top block down so the lowest illegal field decides.
  always_comb begin
    hit  = 1'b0;
    code = '0;
    fld  = '0;
    for (int b = NUM_BLK - 2; b >= 0; b--) begin
      fld = cnt_enc[b*CNT_W +: CNT_W];
      if (fld > CNT_W'(MAX_CNT)) begin
        hit  = 1'b1;
        code = ESC_W'(b * PER) + ESC_W'(fld) - ESC_W'(MAX_CNT + 1);
      end
    end
  end
endmodule

// File: rtl/bundle_hdr_parser.sv
module bundle_hdr_parser #(
  parameter int unsigned NUM_BLK  = 4,
  parameter int unsigned LEN_W    = 8,
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned MAX_CNT  = 5,
  parameter int unsigned MORSEL_W = 4,
  localparam int unsigned HDR_W   = LEN_W + (NUM_BLK - 1) * CNT_W,
  localparam int unsigned ESC_N   = (NUM_BLK - 1) * ((1 << CNT_W) - MAX_CNT - 1),
  localparam int unsigned ESC_W   = (ESC_N > 2) ? $clog2(ESC_N) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [HDR_W-1:0]           in_hdr,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [LEN_W-1:0]           out_len,
  output logic [NUM_BLK*CNT_W-1:0]   out_cnt,
  output logic [NUM_BLK*LEN_W-1:0]   out_start,
  output logic                       out_esc,
  output logic [ESC_W-1:0]           out_esc_code,
  output logic                       out_err
);
  logic [LEN_W-1:0]             f_len;
  logic [(NUM_BLK-1)*CNT_W-1:0] f_cnt;
  logic [NUM_BLK*CNT_W-1:0]     l_cnt;
  logic [NUM_BLK*LEN_W-1:0]     l_start;
  logic                         l_bad, e_hit;
  logic [ESC_W-1:0]             e_code;
  logic                         take;

  assign f_len = in_hdr[LEN_W-1:0];
  assign f_cnt = in_hdr[HDR_W-1:LEN_W];

  bhp_layout #(
    .NUM_BLK(NUM_BLK), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .MAX_CNT(MAX_CNT), .MORSEL_W(MORSEL_W), .HDR_W(HDR_W)
  ) u_layout (
    .len(f_len), .cnt_enc(f_cnt), .cnt_all(l_cnt), .start_all(l_start), .bad(l_bad)
  );

  bhp_esc_detect #(
    .NUM_BLK(NUM_BLK), .CNT_W(CNT_W), .MAX_CNT(MAX_CNT), .ESC_W(ESC_W)
  ) u_esc (
    .cnt_enc(f_cnt), .hit(e_hit), .code(e_code)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_len      <= '0;
      out_cnt      <= '0;
      out_start    <= '0;
      out_esc      <= 1'b0;
      out_esc_code <= '0;
      out_err      <= 1'b0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_len      <= f_len;
      out_esc      <= e_hit;
      out_esc_code <= e_hit ? e_code : '0;
      out_err      <= !e_hit && l_bad;
      if (e_hit || l_bad) begin
        out_cnt   <= '0;
        out_start <= '0;
      end else begin
        out_cnt   <= l_cnt;
        out_start <= l_start;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bhp_checker.sv
module bhp_checker #(
  parameter int unsigned NUM_BLK = 4,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned HDR_W   = 17,
  parameter int unsigned ESC_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [HDR_W-1:0]         in_hdr,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [LEN_W-1:0]         out_len,
  input logic [NUM_BLK*CNT_W-1:0] out_cnt,
  input logic [NUM_BLK*LEN_W-1:0] out_start,
  input logic                     out_esc,
  input logic [ESC_W-1:0]         out_esc_code,
  input logic                     out_err
);
  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_cnt)
      && $stable(out_start) && $stable(out_esc) && $stable(out_esc_code) && $stable(out_err));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_len_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_len == $past(in_hdr[LEN_W-1:0]));

  p_esc_not_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_esc && out_err));

  p_no_layout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_esc || out_err) |-> (out_cnt == '0) && (out_start == '0));
endmodule

bind bundle_hdr_parser bhp_checker #(
  .NUM_BLK(NUM_BLK), .LEN_W(LEN_W), .CNT_W(CNT_W), .HDR_W(HDR_W), .ESC_W(ESC_W)
) u_bhp_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_hdr(in_hdr),
  .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len), .out_cnt(out_cnt),
  .out_start(out_start), .out_esc(out_esc), .out_esc_code(out_esc_code), .out_err(out_err)
);

// File: tb/bundle_hdr_parser_bench.sv
module bundle_hdr_parser_bench;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [7:0]  len;
    logic        esc;
    logic [2:0]  code;
    logic        err;
    logic [11:0] cnt;
    logic [31:0] start;
  } res_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [16:0] in_hdr = '0;
  logic [7:0]  out_len;
  logic [11:0] out_cnt;
  logic [31:0] out_start;
  logic        out_esc, out_err;
  logic [2:0]  out_esc_code;

  int n_chk = 0, n_bad = 0;
  res_t exp_q[$];
  res_t snap;
  logic acc_prev = 1'b0, stall_prev = 1'b0, accepted;

  always #(CLK_P/2) clk = ~clk;

  bundle_hdr_parser u_bundle_hdr_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_hdr(in_hdr),
    .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len), .out_cnt(out_cnt),
    .out_start(out_start), .out_esc(out_esc), .out_esc_code(out_esc_code), .out_err(out_err)
  );

  function automatic int slot_w(int b);
    return (b == 3) ? 17 : 4 * (b + 1);
  endfunction

  // Expected result from R1 field layout and R3..R6 rules.
  function automatic res_t model(logic [16:0] h);
    res_t r;
    int c [4];
    int pos, rem;
    r = '0;
    r.len = h[7:0];
    for (int i = 0; i < 3; i++) c[i] = int'(h[8 + 3*i +: 3]);
    for (int i = 2; i >= 0; i--)
      if (c[i] > 5) begin r.esc = 1'b1; r.code = 3'(2*i + c[i] - 6); end
    if (r.esc) return r;
    pos = 17;
    r.start[7:0] = 8'(pos);
    for (int i = 0; i < 3; i++) begin
      pos = pos + c[i] * slot_w(i);
      r.start[8*(i+1) +: 8] = 8'(pos);
    end
    rem = int'(r.len) - pos;
    if (rem < 0 || (rem % 17) != 0 || (rem / 17) > 5) begin
      r.err = 1'b1; r.start = '0; return r;
    end
    for (int i = 0; i < 3; i++) r.cnt[3*i +: 3] = 3'(c[i]);
    r.cnt[11:9] = 3'(rem / 17);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // One cycle: drive at the falling edge, sample pre-edge values a quarter later.
  task automatic cycle(input logic iv, input logic [16:0] h, input logic ordy);
    res_t e;
    @(negedge clk);
    in_valid = iv; in_hdr = h; out_ready = ordy;
    #(CLK_P/4);
    if (acc_prev) chk(out_valid === 1'b1, "R7 latency", 64'(out_valid), 64'd1);
    if (stall_prev) chk({out_len,out_esc,out_esc_code,out_err,out_cnt,out_start} === snap,
                        "R8 hold", 64'(out_start), 64'(snap.start));
    chk(in_ready === (!out_valid || out_ready), "R8 ready", 64'(in_ready), 64'(!out_valid || out_ready));
    stall_prev = out_valid && !out_ready;
    snap = {out_len, out_esc, out_esc_code, out_err, out_cnt, out_start};
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 extra result", 64'd1, 64'd0);
      else begin
        e = exp_q.pop_front();
        chk(out_len === e.len, "R2 length", 64'(out_len), 64'(e.len));
        chk({out_esc, out_esc_code} === {e.esc, e.code}, "R6 escape", 64'({out_esc,out_esc_code}), 64'({e.esc,e.code}));
        chk(out_err === e.err, "R5 error", 64'(out_err), 64'(e.err));
        chk(out_start === e.start, "R3 starts", 64'(out_start), 64'(e.start));
        chk(out_cnt === e.cnt, "R4 counts", 64'(out_cnt), 64'(e.cnt));
      end
    end
    accepted = in_valid && in_ready;
    acc_prev = accepted;
    if (accepted) exp_q.push_back(model(h));
  endtask

  task automatic send(input logic [16:0] h);
    do cycle(1'b1, h, 1'($urandom % 4 != 0)); while (!accepted);
  endtask

  function automatic logic [16:0] mk(int c0, int c1, int c2, int len);
    return {3'(c2), 3'(c1), 3'(c0), 8'(len)};
  endfunction

  function automatic logic [16:0] rand_hdr();
    int c0, c1, c2, c3, m, b, len;
    m = int'($urandom % 4);
    c0 = int'($urandom % 6); c1 = int'($urandom % 6); c2 = int'($urandom % 6);
    c3 = int'($urandom % 6);
    len = 17 + 4*c0 + 8*c1 + 12*c2 + 17*c3;
    case (m)
      0: return 17'($urandom);
      1: return mk(c0, c1, c2, len);
      2: return mk(c0, c1, c2, len + int'($urandom % 5) - 2);
      default: begin
        b = int'($urandom % 3);
        return mk(b == 0 ? 6 + int'($urandom % 2) : c0, b == 1 ? 7 : c1,
                  b == 2 ? 6 : c2, len);
      end
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    #(CLK_P/4);
    chk(out_valid === 1'b0, "R9 reset valid", 64'(out_valid), 64'd0);
    chk(in_ready === 1'b1, "R9 reset ready", 64'(in_ready), 64'd1);
    @(negedge clk); rst_n = 1'b1;
    #(CLK_P/4);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R9 after reset", 64'({out_valid,in_ready}), 64'b01);

    // Directed corners (R1 layout, R3/R4 layouts, R5 errors, R6 escapes).
    send(mk(0, 0, 0, 17));                 // empty bundle, final count 0
    send(mk(0, 0, 0, 17 + 17*5));          // final count at limit 5
    send(mk(5, 5, 5, 137 + 85));           // every block full
    send(mk(0, 0, 0, 17 + 17*6));          // R5 final count too large
    send(mk(2, 1, 0, 16));                 // R5 negative remainder
    send(mk(1, 0, 0, 17 + 4 + 5));         // R5 not whole slots
    send(mk(6, 0, 0, 17));                 // R6 code 0
    send(mk(7, 0, 7, 200));                // R6 lowest block wins, code 1
    send(mk(0, 0, 7, 3));                  // R6 over error, code 5
    send(mk(3, 2, 1, 17 + 12 + 16 + 12 + 34));
    // Back-pressure: hold result several cycles, R8.
    cycle(1'b1, mk(1, 1, 1, 17 + 24 + 17), 1'b0);
    repeat (3) cycle(1'b0, '0, 1'b0);
    cycle(1'b0, '0, 1'b1);

    for (int i = 0; i < 1500; i++) begin
      if ($urandom % 5 == 0) cycle(1'b0, '0, 1'($urandom % 2));
      else send(rand_hdr());
    end

    repeat (4) cycle(1'b0, '0, 1'b1);
    chk(exp_q.size() == 0, "R7 lost result", 64'(exp_q.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule